// File: doc/BRIEF.md
# Saturating Hit/Miss Event Counters

This block keeps two performance counters for a cache: one counts hits, the other counts misses. Each counter advances by one on every clock in which its single-cycle event input is high and its enable bit is set. When a counter reaches its all-ones value it stops there instead of wrapping.

A four-bit control word drives the block. For each counter it carries an enable bit and a clear bit, and each clear bit sits two positions above its own enable bit. Software clears a counter by writing its clear bit to 1 and then back to 0. The counter stays at zero for as long as the clear bit reads 1.

A single read port returns either count. The select input picks which one. The narrower miss count is zero-extended to the full read width.

Top module: `perf_mon_counters`

## Requirements
- R1: After `rst_ni` is asserted low, both counts read as zero.
- R2: With control bit 0 (hit enable) at 1 and the hit clear bit (bit 2) at 0, the hit count rises by exactly one on each rising clock edge at which `hit_evt_i` is 1. It does not change at an edge where `hit_evt_i` is 0.
- R3: With control bit 1 (miss enable) at 1 and the miss clear bit (bit 3) at 0, the miss count rises by exactly one on each rising clock edge at which `miss_evt_i` is 1.
- R4: A counter whose enable bit is 0 and whose clear bit is 0 keeps its value and ignores its event input.
- R5: A counter whose clear bit is 1 at a rising edge reads zero after that edge. It stays at zero while the bit stays 1, even when the counter is enabled and events arrive. After the bit returns to 0, counting restarts from zero.
- R6: The hit count, `HIT_W` bits wide (32 by default), stops at all-ones (0xFFFFFFFF by default) and stays there while further hits arrive.
- R7: The miss count, `MISS_W` bits wide (16 by default), stops at 0xFFFF and stays there while further misses arrive.
- R8: With `rd_sel_i` = 0, `rd_data_o` shows the hit count. With `rd_sel_i` = 1, it shows the miss count with all bits above `MISS_W` at zero. The read path is combinational.
- R9: The two counters are independent. The enable bit, clear bit and event of one counter never change the other counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 4 | Control word: bit 0 hit enable, bit 1 miss enable, bit 2 hit clear, bit 3 miss clear |
| hit_evt_i | input | 1 | Hit event, one per cycle at most |
| miss_evt_i | input | 1 | Miss event, one per cycle at most |
| rd_sel_i | input | 1 | Read select: 0 hit count, 1 miss count |
| rd_data_o | output | RD_W (32) | Selected count, zero-extended |

## Verification
The bench drives the miss counter all the way to 0xFFFF and keeps feeding it events. A counter that wraps would drop back to a small value at that point. The 32-bit hit limit cannot be reached in the run, so the hit saturation path is exercised on a second instance built with a 10-bit hit counter, which must stay at 1023. The bench holds a clear bit high while the counter is enabled and events keep arriving; a design that gives enable priority over clear would show a nonzero count there. It also checks that the upper 16 bits of a miss read are zero and that operating one counter leaves the other untouched, which catches swapped or shared control bits.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int unsigned CTRL_W      = 4;
  localparam int unsigned HIT_EN_POS  = 0;
  localparam int unsigned MISS_EN_POS = 1;
  // each clear bit lives this many positions above its enable bit
  localparam int unsigned CLR_OFS     = 2;

  typedef enum logic {
    RD_HIT  = 1'b0,
    RD_MISS = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic         evt_i,
  output logic [W-1:0] cnt_o,
  output logic         step_o,
  output logic         full_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  function automatic logic [W-1:0] next_count(input logic [W-1:0] cur,
                                              input logic go);
    if (go && (cur != CNT_MAX)) return cur + W'(1);
    return cur;
  endfunction

  logic [W-1:0] cnt_q;

  assign full_o = (cnt_q == CNT_MAX);
  assign step_o = en_i & evt_i & ~clr_i & ~full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= next_count(cnt_q, en_i & evt_i);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/perf_mon_rdmux.sv
module perf_mon_rdmux #(
  parameter int unsigned HIT_W  = 32,
  parameter int unsigned MISS_W = 16,
  parameter int unsigned RD_W   = 32
) (
  input  logic              sel_i,
  input  logic [HIT_W-1:0]  hit_i,
  input  logic [MISS_W-1:0] miss_i,
  output logic [RD_W-1:0]   data_o
);
  function automatic logic [RD_W-1:0] widen_miss(input logic [MISS_W-1:0] v);
    return RD_W'(v);
  endfunction

  function automatic logic [RD_W-1:0] widen_hit(input logic [HIT_W-1:0] v);
    return RD_W'(v);
  endfunction

  always_comb begin
    data_o = (sel_i == perf_mon_pkg::RD_MISS) ? widen_miss(miss_i) : widen_hit(hit_i);
  end
endmodule

// File: rtl/perf_mon_counters.sv
module perf_mon_counters #(
  parameter int unsigned HIT_W  = 32,
  parameter int unsigned MISS_W = 16,
  parameter int unsigned RD_W   = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [perf_mon_pkg::CTRL_W-1:0]   ctrl_i,
  input  logic                              hit_evt_i,
  input  logic                              miss_evt_i,
  input  logic                              rd_sel_i,
  output logic [RD_W-1:0]                   rd_data_o
);
  import perf_mon_pkg::*;

  localparam int unsigned HIT_CLR_POS  = HIT_EN_POS + CLR_OFS;
  localparam int unsigned MISS_CLR_POS = MISS_EN_POS + CLR_OFS;

  logic              hit_en_w, hit_clr_w, hit_step_w, hit_full_w;
  logic              miss_en_w, miss_clr_w, miss_step_w, miss_full_w;
  logic [HIT_W-1:0]  hit_cnt_w;
  logic [MISS_W-1:0] miss_cnt_w;

  assign hit_en_w   = ctrl_i[HIT_EN_POS];
  assign hit_clr_w  = ctrl_i[HIT_CLR_POS];
  assign miss_en_w  = ctrl_i[MISS_EN_POS];
  assign miss_clr_w = ctrl_i[MISS_CLR_POS];

  sat_counter #(.W(HIT_W)) u_hit (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .en_i  (hit_en_w), .clr_i (hit_clr_w), .evt_i (hit_evt_i),
    .cnt_o (hit_cnt_w), .step_o (hit_step_w), .full_o (hit_full_w)
  );

  sat_counter #(.W(MISS_W)) u_miss (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .en_i  (miss_en_w), .clr_i (miss_clr_w), .evt_i (miss_evt_i),
    .cnt_o (miss_cnt_w), .step_o (miss_step_w), .full_o (miss_full_w)
  );

  perf_mon_rdmux #(.HIT_W(HIT_W), .MISS_W(MISS_W), .RD_W(RD_W)) u_rd (
    .sel_i (rd_sel_i), .hit_i (hit_cnt_w), .miss_i (miss_cnt_w), .data_o (rd_data_o)
  );
endmodule

// File: rtl/perf_mon_chk.sv
module perf_mon_chk #(
  parameter int unsigned HIT_W  = 32,
  parameter int unsigned MISS_W = 16,
  parameter int unsigned RD_W   = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hit_en,
  input logic              hit_clr,
  input logic              hit_evt,
  input logic [HIT_W-1:0]  hit_cnt,
  input logic              miss_en,
  input logic              miss_clr,
  input logic              miss_evt,
  input logic [MISS_W-1:0] miss_cnt,
  input logic              rd_sel,
  input logic [RD_W-1:0]   rd_data
);
  localparam logic [HIT_W-1:0]  HMAX = {HIT_W{1'b1}};
  localparam logic [MISS_W-1:0] MMAX = {MISS_W{1'b1}};

  a_r2_hit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_en && hit_evt && !hit_clr && hit_cnt != HMAX) |=> hit_cnt == $past(hit_cnt) + HIT_W'(1));

  a_r3_miss_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_en && miss_evt && !miss_clr && miss_cnt != MMAX) |=> miss_cnt == $past(miss_cnt) + MISS_W'(1));

  a_r4_hit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_en && !hit_clr) |=> $stable(hit_cnt));

  a_r4_miss_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!miss_en && !miss_clr) |=> $stable(miss_cnt));

  a_r5_hit_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_clr |=> hit_cnt == '0);

  a_r5_miss_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_clr |=> miss_cnt == '0);

  a_r6_hit_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cnt == HMAX && !hit_clr) |=> hit_cnt == HMAX);

  a_r7_miss_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_cnt == MMAX && !miss_clr) |=> miss_cnt == MMAX);

  a_r8_read_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel |-> (rd_data >> MISS_W) == '0);
endmodule

bind perf_mon_counters perf_mon_chk #(.HIT_W(HIT_W), .MISS_W(MISS_W), .RD_W(RD_W)) chk_i (
  .clk_i (clk_i), .rst_ni (rst_ni),
  .hit_en (hit_en_w), .hit_clr (hit_clr_w), .hit_evt (hit_evt_i), .hit_cnt (hit_cnt_w),
  .miss_en (miss_en_w), .miss_clr (miss_clr_w), .miss_evt (miss_evt_i), .miss_cnt (miss_cnt_w),
  .rd_sel (rd_sel_i), .rd_data (rd_data_o)
);

// File: tb/perf_mon_counters_tb_top.sv
module perf_mon_counters_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ctrl = 4'b0;
  logic        hit = 1'b0, miss = 1'b0, sel = 1'b0;
  logic [31:0] rd, rd_s;
  int          n_chk = 0, n_err = 0;

  always #4 clk = ~clk;   // 125 MHz

  perf_mon_counters dut_i (
    .clk_i (clk), .rst_ni (rst_n), .ctrl_i (ctrl),
    .hit_evt_i (hit), .miss_evt_i (miss), .rd_sel_i (sel), .rd_data_o (rd)
  );

  // small hit counter so that its saturation is reachable
  perf_mon_counters #(.HIT_W(10)) dut_small_i (
    .clk_i (clk), .rst_ni (rst_n), .ctrl_i (ctrl),
    .hit_evt_i (hit), .miss_evt_i (miss), .rd_sel_i (sel), .rd_data_o (rd_s)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic rd_hit(output logic [31:0] v);
    sel = 1'b0; #1; v = rd;
  endtask

  task automatic rd_miss(output logic [31:0] v);
    sel = 1'b1; #1; v = rd;
  endtask

  task automatic zero_all();
    hit = 0; miss = 0; ctrl = 4'b1100; tick(1); ctrl = 4'b0000;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst_n = 0; tick(2); rst_n = 1; tick(1);
    rd_hit(v);  chk("R1 hit after reset", v, 0);
    rd_miss(v); chk("R1 miss after reset", v, 0);
  endtask

  task automatic t_hit_count();
    logic [31:0] v;
    zero_all();
    ctrl = 4'b0001; hit = 1; tick(5);
    hit = 0; tick(2);
    hit = 1; tick(1); hit = 0; tick(1);
    rd_hit(v); chk("R2 hit count with gaps", v, 6);
    rd_miss(v); chk("R9 miss untouched by hits", v, 0);
  endtask

  task automatic t_miss_count();
    logic [31:0] v;
    zero_all();
    ctrl = 4'b0010; miss = 1; tick(7);
    miss = 0; tick(3);
    rd_miss(v); chk("R3 miss count", v, 7);
    rd_hit(v);  chk("R9 hit untouched by misses", v, 0);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    zero_all();
    ctrl = 4'b0011; hit = 1; miss = 1; tick(4);
    ctrl = 4'b0000; tick(6);
    hit = 0; miss = 0;
    rd_hit(v);  chk("R4 disabled hit holds", v, 4);
    rd_miss(v); chk("R4 disabled miss holds", v, 4);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    zero_all();
    ctrl = 4'b0011; hit = 1; miss = 1; tick(3);
    ctrl = 4'b0111; tick(1);
    rd_hit(v);  chk("R5 hit cleared after one edge", v, 0);
    rd_miss(v); chk("R9 miss keeps counting during hit clear", v, 4);
    tick(3);
    rd_hit(v);  chk("R5 hit held at zero while enabled", v, 0);
    ctrl = 4'b1011; tick(2);
    rd_miss(v); chk("R5 miss held at zero while enabled", v, 0);
    rd_hit(v);  chk("R5 hit restarts from zero", v, 2);
    hit = 0; miss = 0; ctrl = 4'b0000;
  endtask

  task automatic t_miss_sat();
    logic [31:0] v;
    zero_all();
    ctrl = 4'b0010; miss = 1; tick(65535 + 20);
    rd_miss(v); chk("R7 miss saturates at 0xFFFF", v, 32'h0000_FFFF);
    chk("R8 miss upper read bits zero", {16'h0, v[31:16]}, 0);
    rd_hit(v);  chk("R9 hit stays zero", v, 0);
    miss = 0; ctrl = 4'b1000; tick(1); ctrl = 4'b0000;
    rd_miss(v); chk("R5 clear from saturation", v, 0);
  endtask

  task automatic t_hit_sat();
    zero_all();
    ctrl = 4'b0001; hit = 1; tick(1023 + 9);
    sel = 1'b0; #1;
    chk("R6 hit saturates at all-ones (10-bit build)", rd_s, 32'd1023);
    chk("R2 full-width hit keeps counting", rd, 32'd1032);
    hit = 0; ctrl = 4'b0000;
  endtask

  task automatic t_read_mux();
    logic [31:0] v;
    zero_all();
    ctrl = 4'b0011; hit = 1; tick(9); hit = 0; miss = 1; tick(2); miss = 0; ctrl = 0;
    rd_hit(v);  chk("R8 select 0 returns hit", v, 9);
    rd_miss(v); chk("R8 select 1 returns miss", v, 2);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_hit_count();
    t_miss_count();
    t_disable();
    t_clear();
    t_read_mux();
    t_hit_sat();
    t_miss_sat();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule